// File: doc/BRIEF.md
# Accumulator ALU with Flag Write Mask

A purely combinational datapath unit for a small accumulator machine. Each cycle the surrounding core presents an operation code, the accumulator value, a second operand (a memory byte or a literal already selected by decode) and the four current status flags: zero, carry, half carry and signed overflow. The unit returns the result byte, a full set of outgoing flags and a four-bit mask that marks which flags the operation actually wrote. The core can therefore commit `flags_o` directly or gate its flag register with `fmask_o`.

The operation set covers binary and single-operand add and subtract, with and without carry. It also covers increment and decrement, the bitwise operations, complement and two's-complement negate, logical shifts, rotates through carry, and nibble swap. It includes the flag-neutral moves used for loads, stores, clear and exchange. Single-operand operations act on `opa_i`; decode routes a memory byte onto that port for memory-form unary instructions.

Flag bit positions in `flags_i`, `flags_o` and `fmask_o` are: bit 0 zero (Z), bit 1 carry/borrow (C), bit 2 half carry (H), bit 3 overflow (V).

Top module: `acc_alu`

## Requirements
- R1: Codes 0 (opa+opb), 2 (opa+opb+C), 4 (opa+1) and 6 (opa+C) write all four flags (mask 4'b1111). C is the unsigned carry out of bit 7, H is the carry out of bit 3, V is two's-complement overflow of the 8-bit result, and Z is set exactly when the result is zero.
- R2: Codes 1 (opa−opb), 3 (opa−opb−C), 5 (opa−1) and 7 (opa−C) write all four flags. C is set when the unsigned minuend is smaller than the subtrahend plus the incoming borrow. H is the borrow out of the low nibble. V is signed overflow, and Z is set when the result is zero.
- R3: Codes 8 (AND), 9 (OR), 10 (XOR), 11 (NOT opa) and 12 (negate opa, 0−opa) write only Z (mask 4'b0001).
- R4: Code 13 shifts opa right with 0 entering bit 7, and code 14 shifts it left with 0 entering bit 0. Both write only C (mask 4'b0010), which takes the bit shifted out.
- R5: Code 15 rotates the 9-bit value C:opa right, so the old C enters bit 7 and bit 0 leaves into C. Code 16 rotates opa:C left, so the old C enters bit 0 and bit 7 leaves into C. Both write only C.
- R6: Code 17 returns opa with its two nibbles exchanged and writes no flag.
- R7: Code 18 (load from memory) returns opb and writes only Z. Code 19 (load literal) returns opb and writes no flag. Code 20 (store) returns opa and writes no flag.
- R8: Code 21 (clear) returns zero, and code 22 (exchange) returns opb. Neither writes a flag.
- R9: Every flag whose mask bit is clear leaves on `flags_o` with the value it had on `flags_i`.
- R10: Codes 23 to 31 return zero with an empty mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| opa_i | input | 8 | Accumulator operand |
| opb_i | input | 8 | Second operand (memory or literal) |
| flags_i | input | 4 | Incoming flags {V,H,C,Z} |
| res_o | output | 8 | Result byte |
| flags_o | output | 4 | Outgoing flags {V,H,C,Z} |
| fmask_o | output | 4 | Per-flag write mask |

## Verification
The hardest cases to reach are where the incoming carry alone tips a result across a boundary. Examples are 0x7F plus zero plus carry overflowing, or a borrow through a zero low nibble in subtract-with-carry, and they only appear when the operand pair sits exactly at the edge and C is set. The stimulus therefore drives every operation over all 256 accumulator values. It pairs each with a spread of second operands that includes the accumulator's own value and 0x80, and applies each pair with C clear and C set. Half carry, overflow and borrow are each computed in integer arithmetic for comparison.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OP_W   = 5;
  localparam int FLAG_N = 4;

  // Flag bit positions
  localparam int FZ = 0;
  localparam int FC = 1;
  localparam int FH = 2;
  localparam int FV = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_SUB  = 5'd1,
    OP_ADC  = 5'd2,
    OP_SBC  = 5'd3,
    OP_INC  = 5'd4,
    OP_DEC  = 5'd5,
    OP_ADCF = 5'd6,
    OP_SBCF = 5'd7,
    OP_AND  = 5'd8,
    OP_OR   = 5'd9,
    OP_XOR  = 5'd10,
    OP_NOT  = 5'd11,
    OP_NEG  = 5'd12,
    OP_SHR  = 5'd13,
    OP_SHL  = 5'd14,
    OP_RCR  = 5'd15,
    OP_RCL  = 5'd16,
    OP_SWAP = 5'd17,
    OP_LDM  = 5'd18,
    OP_LDK  = 5'd19,
    OP_STA  = 5'd20,
    OP_CLR  = 5'd21,
    OP_XCH  = 5'd22
  } alu_op_e;

  typedef enum logic [2:0] {
    CL_ARITH,
    CL_LOGIC,
    CL_SHIFT,
    CL_ZONLY,
    CL_NONE
  } alu_class_e;

  function automatic alu_class_e op_class(alu_op_e op);
    case (op)
      OP_ADD, OP_SUB, OP_ADC, OP_SBC,
      OP_INC, OP_DEC, OP_ADCF, OP_SBCF:         return CL_ARITH;
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_NEG:    return CL_LOGIC;
      OP_SHR, OP_SHL, OP_RCR, OP_RCL:           return CL_SHIFT;
      OP_LDM:                                   return CL_ZONLY;
      default:                                  return CL_NONE;
    endcase
  endfunction

  function automatic logic [FLAG_N-1:0] class_mask(alu_class_e cl);
    case (cl)
      CL_ARITH: return 4'b1111;
      CL_LOGIC: return 4'b0001;
      CL_SHIFT: return 4'b0010;
      CL_ZONLY: return 4'b0001;
      default:  return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cf_in,
  output logic [W-1:0]   sum,
  output logic           c_out,
  output logic           h_out,
  output logic           v_out
);
  localparam int H  = W / 2;
  localparam int W1 = W + 1;
  localparam int H1 = H + 1;

  logic [W-1:0] y;
  logic         ci;
  logic         sub;

  // Subtraction is a + ~y + 1 with the carry sense inverted on output
  always_comb begin
    y   = '0;
    ci  = 1'b0;
    sub = 1'b0;
    case (op)
      OP_ADD:  begin y = b;           ci = 1'b0;   sub = 1'b0; end
      OP_ADC:  begin y = b;           ci = cf_in;  sub = 1'b0; end
      OP_INC:  begin y = '0;          ci = 1'b1;   sub = 1'b0; end
      OP_ADCF: begin y = '0;          ci = cf_in;  sub = 1'b0; end
      OP_SUB:  begin y = ~b;          ci = 1'b1;   sub = 1'b1; end
      OP_SBC:  begin y = ~b;          ci = ~cf_in; sub = 1'b1; end
      OP_DEC:  begin y = ~W'(1);      ci = 1'b1;   sub = 1'b1; end
      OP_SBCF: begin y = '1;          ci = ~cf_in; sub = 1'b1; end
      default: begin y = '0;          ci = 1'b0;   sub = 1'b0; end
    endcase
  end

  logic [W1-1:0] full;
  logic [H1-1:0] low;

  assign full  = {1'b0, a} + {1'b0, y} + W1'(ci);
  assign low   = {1'b0, a[H-1:0]} + {1'b0, y[H-1:0]} + H1'(ci);
  assign sum   = full[W-1:0];
  assign c_out = full[W] ^ sub;
  assign h_out = low[H] ^ sub;
  assign v_out = (a[W-1] == y[W-1]) && (full[W-1] != a[W-1]);

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e       op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [W-1:0]  res
);
  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOT:  res = ~a;
      OP_NEG:  res = '0 - a;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e       op,
  input  logic [W-1:0]  a,
  input  logic          cf_in,
  output logic [W-1:0]  res,
  output logic          c_out
);
  localparam int H = W / 2;

  always_comb begin
    res   = '0;
    c_out = cf_in;
    case (op)
      OP_SHR:  begin res = {1'b0, a[W-1:1]};  c_out = a[0];   end
      OP_SHL:  begin res = {a[W-2:0], 1'b0};  c_out = a[W-1]; end
      OP_RCR:  begin res = {cf_in, a[W-1:1]}; c_out = a[0];   end
      OP_RCL:  begin res = {a[W-2:0], cf_in}; c_out = a[W-1]; end
      OP_SWAP: begin res = {a[H-1:0], a[W-1:H]}; end
      default: begin res = '0; end
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [W-1:0]      opa_i,
  input  logic [W-1:0]      opb_i,
  input  logic [FLAG_N-1:0] flags_i,
  output logic [W-1:0]      res_o,
  output logic [FLAG_N-1:0] flags_o,
  output logic [FLAG_N-1:0] fmask_o
);
  alu_op_e    op;
  alu_class_e cl;

  assign op = alu_op_e'(op_i);
  assign cl = op_class(op);

  logic [W-1:0] ar_res, lg_res, sh_res;
  logic         ar_c, ar_h, ar_v, sh_c;

  alu_arith #(.W(W)) u_arith (
    .op    (op),
    .a     (opa_i),
    .b     (opb_i),
    .cf_in (flags_i[FC]),
    .sum   (ar_res),
    .c_out (ar_c),
    .h_out (ar_h),
    .v_out (ar_v)
  );

  alu_logic #(.W(W)) u_logic (
    .op  (op),
    .a   (opa_i),
    .b   (opb_i),
    .res (lg_res)
  );

  alu_shift #(.W(W)) u_shift (
    .op    (op),
    .a     (opa_i),
    .cf_in (flags_i[FC]),
    .res   (sh_res),
    .c_out (sh_c)
  );

  // Result selection
  always_comb begin
    case (op)
      OP_SWAP:               res_o = sh_res;
      OP_LDM, OP_LDK,
      OP_XCH:                res_o = opb_i;
      OP_STA:                res_o = opa_i;
      OP_CLR:                res_o = '0;
      default: begin
        case (cl)
          CL_ARITH: res_o = ar_res;
          CL_LOGIC: res_o = lg_res;
          CL_SHIFT: res_o = sh_res;
          default:  res_o = '0;
        endcase
      end
    endcase
  end

  // Candidate flag values before masking
  logic [FLAG_N-1:0] cand;
  always_comb begin
    cand     = flags_i;
    cand[FZ] = (res_o == '0);
    cand[FC] = (cl == CL_SHIFT) ? sh_c : ar_c;
    cand[FH] = ar_h;
    cand[FV] = ar_v;
  end

  assign fmask_o = class_mask(cl);

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    assign flags_o[i] = fmask_o[i] ? cand[i] : flags_i[i];
  end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic [OP_W-1:0]   op_i,
  input logic [W-1:0]      opa_i,
  input logic [FLAG_N-1:0] flags_i,
  input logic [W-1:0]      res_o,
  input logic [FLAG_N-1:0] flags_o,
  input logic [FLAG_N-1:0] fmask_o
);
  localparam int H = W / 2;

  always_comb begin
    // R9: unwritten flags pass through
    a_r9_unmasked_hold: assert (((~fmask_o) & (flags_o ^ flags_i)) == '0)
      else $error("R9 unmasked flag changed");
    // R1: zero flag tracks the result whenever written
    a_r1_zero_tracks_result: assert (!fmask_o[FZ] || (flags_o[FZ] == (res_o == '0)))
      else $error("R1 zero flag mismatch");
    // R3: logic class writes Z only
    a_r3_logic_z_only: assert (!(op_i inside {5'd8, 5'd9, 5'd10, 5'd11, 5'd12}) || fmask_o == 4'b0001)
      else $error("R3 mask wrong");
    // R4: shifts write C only
    a_r4_shift_c_only: assert (!(op_i inside {5'd13, 5'd14, 5'd15, 5'd16}) || fmask_o == 4'b0010)
      else $error("R4 mask wrong");
    // R5: rotate right moves old carry into the top bit
    a_r5_rcr_carry_in: assert (op_i != 5'd15 || (res_o[W-1] == flags_i[FC] && flags_o[FC] == opa_i[0]))
      else $error("R5 rotate right wrong");
    // R6: swap exchanges nibbles with no flag written
    a_r6_swap_nibbles: assert (op_i != 5'd17 || (res_o == {opa_i[H-1:0], opa_i[W-1:H]} && fmask_o == '0))
      else $error("R6 swap wrong");
    // R10: unused codes are inert
    a_r10_unused_inert: assert (op_i < 5'd23 || (res_o == '0 && fmask_o == '0))
      else $error("R10 unused code active");
  end
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .op_i    (op_i),
  .opa_i   (opa_i),
  .flags_i (flags_i),
  .res_o   (res_o),
  .flags_o (flags_o),
  .fmask_o (fmask_o)
);

// File: tb/acc_alu_test.sv
module acc_alu_test;
  logic       clk;
  logic       rst_n;
  logic [4:0] op_i;
  logic [7:0] opa_i, opb_i;
  logic [3:0] flags_i;
  logic [7:0] res_o;
  logic [3:0] flags_o, fmask_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  acc_alu uut (
    .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i), .flags_i(flags_i),
    .res_o(res_o), .flags_o(flags_o), .fmask_o(fmask_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic string req_of(int op);
    if (op == 0 || op == 2 || op == 4 || op == 6) return "R1";
    if (op == 1 || op == 3 || op == 5 || op == 7) return "R2";
    if (op >= 8 && op <= 12)  return "R3";
    if (op == 13 || op == 14) return "R4";
    if (op == 15 || op == 16) return "R5";
    if (op == 17)             return "R6";
    if (op >= 18 && op <= 20) return "R7";
    if (op == 21 || op == 22) return "R8";
    return "R10";
  endfunction

  function automatic int sgn(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  // Reference model from the requirements; flags {V,H,C,Z}
  task automatic model(input int op, input int a, input int b, input logic [3:0] fi,
                       output logic [7:0] r, output logic [3:0] fo, output logic [3:0] m);
    int c, bb, t, s;
    logic z, cy, hc, ov;
    c  = int'(fi[1]);
    fo = fi;
    m  = 4'b0000;
    r  = 8'h00;
    if (op <= 7) begin
      case (op)
        0, 1:    begin bb = b; c = 0; end
        2, 3:    bb = b;
        4, 5:    begin bb = 1; c = 0; end
        default: bb = 0;
      endcase
      if (op % 2 == 0) begin
        t  = a + bb + c;
        cy = (t > 255);
        hc = ((a % 16) + (bb % 16) + c) > 15;
        s  = sgn(a) + sgn(bb) + c;
      end else begin
        t  = a - bb - c;
        cy = (t < 0);
        hc = ((a % 16) - (bb % 16) - c) < 0;
        s  = sgn(a) - sgn(bb) - c;
      end
      r  = 8'(t);
      ov = (s > 127) || (s < -128);
      z  = (r == 8'h00);
      fo = {ov, hc, cy, z};
      m  = 4'b1111;
    end else if (op <= 12) begin
      case (op)
        8:       r = 8'(a & b);
        9:       r = 8'(a | b);
        10:      r = 8'(a ^ b);
        11:      r = 8'(255 - a);
        default: r = 8'(256 - a);
      endcase
      fo[0] = (r == 8'h00);
      m = 4'b0001;
    end else if (op <= 16) begin
      case (op)
        13: begin r = 8'(a / 2);             fo[1] = a[0]; end
        14: begin r = 8'((a * 2) % 256);     fo[1] = a[7]; end
        15: begin r = 8'(a / 2 + 128 * c);   fo[1] = a[0]; end
        default: begin r = 8'((a * 2) % 256 + c); fo[1] = a[7]; end
      endcase
      m = 4'b0010;
    end else begin
      case (op)
        17: r = 8'((a % 16) * 16 + a / 16);
        18: begin r = 8'(b); fo[0] = (b == 0); m = 4'b0001; end
        19: r = 8'(b);
        20: r = 8'(a);
        21: r = 8'h00;
        22: r = 8'(b);
        default: r = 8'h00;
      endcase
    end
  endtask

  task automatic apply(input int op, input int a, input int b, input logic [3:0] fi);
    logic [7:0] er;
    logic [3:0] ef, em;
    op_i = 5'(op); opa_i = 8'(a); opb_i = 8'(b); flags_i = fi;
    #1;
    model(op, a, b, fi, er, ef, em);
    n_chk++;
    if (res_o !== er || flags_o !== ef || fmask_o !== em) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h fi=%b: got res=%h flags=%b mask=%b, exp res=%h flags=%b mask=%b",
               req_of(op), op, a, b, fi, res_o, flags_o, fmask_o, er, ef, em);
    end
    // R9: unmasked flags equal incoming flags
    n_chk++;
    if (((~fmask_o) & (flags_o ^ fi)) !== 4'b0000) begin
      n_fail++;
      $display("FAIL R9 op=%0d: got flags=%b mask=%b, exp unmasked bits of %b", op, flags_o, fmask_o, fi);
    end
    #1;
  endtask

  initial begin
    op_i = '0; opa_i = '0; opb_i = '0; flags_i = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Directed boundary cases
    apply(6, 8'h7F, 0, 4'b0010);   // R1 0x7F + C -> 0x80, V and H set
    apply(2, 8'hFF, 8'h00, 4'b0010); // R1 carry-only wrap to zero
    apply(3, 8'h10, 8'h00, 4'b0010); // R2 half borrow from C alone
    apply(5, 8'h80, 0, 4'b0000);   // R2 decrement overflow
    apply(12, 8'h80, 0, 4'b1110);  // R3 negate 0x80
    apply(15, 8'h01, 0, 4'b0010);  // R5 rotate right carry in
    apply(16, 8'h80, 0, 4'b0000);  // R5 rotate left carry out
    apply(17, 8'hA5, 0, 4'b1111);  // R6 swap
    apply(19, 0, 8'h00, 4'b0000);  // R7 literal zero keeps Z clear
    apply(21, 8'h33, 8'h44, 4'b1010); // R8 clear
    apply(30, 8'hFF, 8'hFF, 4'b1111); // R10 unused code
    // Sweep
    for (int op = 0; op < 32; op++)
      for (int a = 0; a < 256; a++)
        for (int j = 0; j < 18; j++)
          for (int k = 0; k < 2; k++) begin
            int b;
            b = (j < 16) ? j * 17 : ((j == 16) ? a : 128);
            apply(op, a, b, {a[1] ^ 1'b1, 1'(b % 2), 1'(k), 1'(a % 2)});
          end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 200000; cyc++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule